// File: doc/BRIEF.md
# Dual-Mode SPI Serial Clock Divider

This block derives the serial clock of an SPI shifter from the module clock. A control word carries two divisor fields and a select bit. The select bit picks one of two divide schemes. The power-of-two scheme divides by 2^M. The linear scheme divides by an even ratio 2×(N+1). The block drives a 50% duty serial clock level and two single-cycle strobes. The strobes mark where the serial clock rises and where it falls, so the shifter can launch and capture data on them.

Software picks the divisor values and writes the control word. It then raises the run enable. The divider captures the control word once, in the cycle it starts, and keeps that setting until run enable drops. While idle, the counter stays cleared and the serial clock sits low. A later start therefore always begins on a clean half-period boundary.

Top module: `spi_sck_divider`

## Requirements
- R1: A synchronous active-high reset drives sck, sck_rise and sck_fall to 0 on the next clock edge. This holds even if run_en is high.
- R2: With ctl_word bit 12 set to 1 (linear mode), the half-period is H = N+1 module-clock cycles, where N = ctl_word[7:0]. The sck period is therefore 2×(N+1). N=0 gives a period of 2 and N=255 gives a period of 512.
- R3: With ctl_word bit 12 set to 0 (power-of-two mode) and M = ctl_word[11:8] at least 1, the half-period is H = 2^(M-1) cycles. The sck period is therefore 2^M. M=15 gives a half-period of 16384.
- R4: In power-of-two mode with M=0, a strobe is produced on every cycle, alternating rising and falling. The half-period is one cycle.
- R5: Let the start edge be the clock edge at which run_en is first sampled high. After the start edge, sck is 0. sck first becomes 1 after edge number H counted from the start edge, and it toggles again every H edges after that.
- R6: sck_rise is high for exactly the cycle in which sck has just changed from 0 to 1. sck_fall is high for exactly the cycle in which sck has just changed from 1 to 0. The two are never high together.
- R7: After any edge at which run_en is sampled low, sck, sck_rise and sck_fall are 0 and the half-period counter is cleared. A later start then follows R5 exactly.
- R8: A change of ctl_word while running has no effect on the sck timing. The new value is used from the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Module clock |
| rst | input | 1 | Synchronous active-high reset |
| run_en | input | 1 | Divider runs while high; clears and idles while low |
| ctl_word | input | 13 | [7:0] linear divisor N, [11:8] power-of-two exponent M, [12] mode select (1 = linear) |
| sck | output | 1 | Serial clock level, idle low |
| sck_rise | output | 1 | One-cycle strobe on each rising sck transition |
| sck_fall | output | 1 | One-cycle strobe on each falling sck transition |

## Verification
The bench follows sck and both strobes cycle by cycle. It covers the extreme settings of both schemes: N=0, N=255, M=0, M=1 and M=15. An off-by-one in either decode would stretch or shrink every half-period, and a swapped select bit would run the wrong scheme entirely. The bench rewrites ctl_word in the middle of a run, then stops at an arbitrary point inside a half-period and restarts. A design that loads the register continuously would change speed mid-run. A design that does not clear its counter would put the first edge of the next run in the wrong cycle. A synchronous reset is applied while the divider is running, to catch outputs that ignore reset when run_en is high.

// File: rtl/spi_div_pkg.sv
package spi_div_pkg;
  // Meaning of the mode select bit in the control word
  typedef enum logic {
    DIV_POW2   = 1'b0,
    DIV_LINEAR = 1'b1
  } div_mode_e;
endpackage

// File: rtl/sckdiv_cfg.sv
// Decodes the control word into a half-period length and holds it for a run.
module sckdiv_cfg
  import spi_div_pkg::*;
#(
  parameter int N_W = 8,
  parameter int M_W = 4,
  parameter int H_W = 15
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           load,
  input  logic           running,
  input  logic [N_W-1:0] lin_div,
  input  logic [M_W-1:0] pow_exp,
  input  div_mode_e      mode,
  output logic [H_W-1:0] half_q
);
  logic [H_W-1:0] half_d;
  logic [H_W-1:0] one_h;

  assign one_h = H_W'(1);

  always_comb begin
    if (mode == DIV_LINEAR) begin
      half_d = H_W'(lin_div) + one_h;
    end else if (pow_exp == '0) begin
      half_d = one_h;
    end else begin
      half_d = one_h << (pow_exp - M_W'(1));
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      half_q <= one_h;
    end else if (load) begin
      half_q <= half_d;
    end
  end

  // R8: setting is frozen for the whole run
  p_cfg_hold_r8: assert property (@(posedge clk) disable iff (rst)
    (running && !load && $past(running)) |-> $stable(half_q));

  // R2, R3: a half-period is never zero cycles
  p_half_nonzero_r3: assert property (@(posedge clk) disable iff (rst)
    half_q != '0);
endmodule

// File: rtl/sckdiv_timer.sv
// Counts module-clock cycles within a half-period and flags its last cycle.
module sckdiv_timer #(
  parameter int H_W = 15
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           run_en,
  input  logic           running,
  input  logic [H_W-1:0] half_q,
  output logic           tick
);
  logic [H_W-1:0] cnt;
  logic           last;

  assign last = (cnt == half_q - H_W'(1));
  assign tick = running && run_en && last;

  always_ff @(posedge clk) begin
    if (rst || !run_en || !running) begin
      cnt <= '0;
    end else if (last) begin
      cnt <= '0;
    end else begin
      cnt <= cnt + H_W'(1);
    end
  end

  // R2, R3: counter stays inside the latched half-period
  p_cnt_bound_r2: assert property (@(posedge clk) disable iff (rst)
    running |-> (cnt < half_q));

  // R7: counter is cleared after an idle cycle
  p_cnt_clear_r7: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (cnt == '0));
endmodule

// File: rtl/sckdiv_out.sv
// Registered serial clock level and its edge strobes.
module sckdiv_out (
  input  logic clk,
  input  logic rst,
  input  logic run_en,
  input  logic tick,
  output logic sck,
  output logic sck_rise,
  output logic sck_fall
);
  always_ff @(posedge clk) begin
    if (rst || !run_en) begin
      sck      <= 1'b0;
      sck_rise <= 1'b0;
      sck_fall <= 1'b0;
    end else begin
      sck_rise <= tick && !sck;
      sck_fall <= tick && sck;
      if (tick) begin
        sck <= !sck;
      end
    end
  end

  p_strobe_excl_r6: assert property (@(posedge clk) disable iff (rst)
    !(sck_rise && sck_fall));

  p_rise_edge_r6: assert property (@(posedge clk) disable iff (rst)
    sck_rise |-> (sck && !$past(sck)));

  p_fall_edge_r6: assert property (@(posedge clk) disable iff (rst)
    sck_fall |-> (!sck && $past(sck)));

  p_idle_r7: assert property (@(posedge clk) disable iff (rst)
    !run_en |=> (!sck && !sck_rise && !sck_fall));
endmodule

// File: rtl/spi_sck_divider.sv
module spi_sck_divider
  import spi_div_pkg::*;
#(
  parameter int N_W = 8,
  parameter int M_W = 4,
  localparam int CTL_W = N_W + M_W + 1,
  localparam int POW_W = (1 << M_W) - 1,
  localparam int H_W   = (N_W + 1 > POW_W) ? N_W + 1 : POW_W
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run_en,
  input  logic [CTL_W-1:0] ctl_word,
  output logic             sck,
  output logic             sck_rise,
  output logic             sck_fall
);
  logic           running;
  logic           load;
  logic           tick;
  logic [H_W-1:0] half_q;
  div_mode_e      mode;

  assign mode = div_mode_e'(ctl_word[N_W+M_W]);
  assign load = run_en && !running;

  always_ff @(posedge clk) begin
    if (rst) begin
      running <= 1'b0;
    end else begin
      running <= run_en;
    end
  end

  sckdiv_cfg #(.N_W(N_W), .M_W(M_W), .H_W(H_W)) u_cfg (
    .clk     (clk),
    .rst     (rst),
    .load    (load),
    .running (running),
    .lin_div (ctl_word[N_W-1:0]),
    .pow_exp (ctl_word[N_W+M_W-1:N_W]),
    .mode    (mode),
    .half_q  (half_q)
  );

  sckdiv_timer #(.H_W(H_W)) u_timer (
    .clk     (clk),
    .rst     (rst),
    .run_en  (run_en),
    .running (running),
    .half_q  (half_q),
    .tick    (tick)
  );

  sckdiv_out u_out (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .tick     (tick),
    .sck      (sck),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  // R1: reset clears the outputs on the next edge
  p_reset_r1: assert property (@(posedge clk)
    rst |=> (!sck && !sck_rise && !sck_fall));
endmodule

// File: tb/test_spi_sck_divider.sv
`timescale 1ns/1ps
module test_spi_sck_divider;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        run_en = 1'b0;
  logic [12:0] ctl_word = '0;
  logic        sck, sck_rise, sck_fall;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #5 clk = ~clk;

  spi_sck_divider i_spi_sck_divider (
    .clk      (clk),
    .rst      (rst),
    .run_en   (run_en),
    .ctl_word (ctl_word),
    .sck      (sck),
    .sck_rise (sck_rise),
    .sck_fall (sck_fall)
  );

  function automatic logic [12:0] lin(input int n);
    return {1'b1, 4'd0, 8'(n)};
  endfunction

  function automatic logic [12:0] pw(input int m);
    return {1'b0, 4'(m), 8'hA5};
  endfunction

  task automatic check3(input string tag, input logic [2:0] exp);
    checks++;
    if ({sck, sck_rise, sck_fall} !== exp) begin
      errors++;
      $display("FAIL %s: {sck,rise,fall} actual=%b expected=%b at %0t",
               tag, {sck, sck_rise, sck_fall}, exp, $time);
    end
  endtask

  // Start a run; check n cycles against half-period h.
  // If swap, the control word is rewritten mid-run (R8).
  task automatic run_case(input logic [12:0] ctl, input int h, input int n,
                          input string tag, input bit swap,
                          input logic [12:0] ctl2);
    @(negedge clk);
    ctl_word = ctl;
    run_en   = 1'b1;
    @(posedge clk);
    @(negedge clk);
    check3({tag, " R5 start"}, 3'b000);
    for (int j = 1; j <= n; j++) begin
      @(negedge clk);
      begin
        int ph = j / h;
        bit edge_now = (j % h) == 0;
        bit lvl = ph[0];
        check3(tag, {lvl, edge_now && lvl, edge_now && !lvl});
      end
      if (swap && j == 2) ctl_word = ctl2;
    end
    run_en = 1'b0;
    @(negedge clk);
    check3({tag, " R7 stop"}, 3'b000);
    @(negedge clk);
    check3({tag, " R7 idle"}, 3'b000);
  endtask

  task automatic t_reset;
    repeat (3) @(negedge clk);
    check3("R1 reset", 3'b000);
    rst = 1'b0;
  endtask

  task automatic t_reset_mid;
    @(negedge clk);
    ctl_word = lin(0);
    run_en = 1'b1;
    repeat (5) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check3("R1 reset while running", 3'b000);
    @(negedge clk);
    check3("R1 reset hold", 3'b000);
    run_en = 1'b0;
    rst = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    t_reset();
    run_case(lin(0),   1,   8,  "R2 linear N=0", 0, '0);
    run_case(lin(3),   4,   21, "R2 linear N=3", 0, '0);
    run_case(lin(255), 256, 1030, "R2 linear N=255", 0, '0);
    run_case(pw(0),    1,   9,  "R4 pow2 M=0", 0, '0);
    run_case(pw(1),    1,   6,  "R3 pow2 M=1", 0, '0);
    run_case(pw(3),    4,   19, "R3 pow2 M=3", 0, '0);
    run_case(pw(15),   16384, 32770, "R3 pow2 M=15", 0, '0);
    // R8: rewrite to N=9 while running at N=2; stop mid half-period
    run_case(lin(2),   3,   17, "R8 hold N=2", 1, lin(9));
    // R7/R8: restart picks up N=9 with clean timing
    run_case(lin(9),   10,  43, "R8 restart N=9", 0, '0);
    // R6/R7: a short run, stop, restart, same setting
    run_case(lin(1),   2,   5,  "R6 short", 0, '0);
    run_case(lin(1),   2,   12, "R7 restart", 0, '0);
    t_reset_mid();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++;
      errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule